// File: doc/BRIEF.md
# Dual-Channel Transmit Frame Buffer

This block is the transmit half of a small Ethernet MAC, as seen from a 32-bit register bus. Software loads frame bytes into one of two channel buffers by writing 32-bit words to a single data register. Each word is split into four bytes, lowest byte first. A select register decides which buffer receives the words. Each buffer holds 4096 bytes. Each channel has its own length register and its own start register.

A start command streams the lesser of the programmed length and the bytes held out of a byte-wide valid/ready port, with a last flag on the final byte. When the frame ends, the channel's buffer and length are emptied and the channel's interrupt status bit is set. The interrupt output is the OR of the status bits that are enabled. A soft reset, issued through the control register, returns the programmable state and both buffers to empty.

Register map (byte offsets, 32-bit access): control 0x00, channel select 0x04, length for channel 0 at 0x08, length for channel 1 at 0x0C, start for channel 0 at 0x10, start for channel 1 at 0x14, transmit data 0x18, interrupt enable 0x1C, interrupt status 0x20. Register reads return data one cycle after the read strobe. Addresses not in this map read as 0.

Top module: `dual_tx_frame_fifo`

## Requirements
- R1: A write to the select register stores values 0 and 1 as given. Any other value stores 0. The register reads back the stored value.
- R2: Each write to the data register appends bits [7:0], [15:8], [23:16] and [31:24] of the word to the selected channel, in that order. A frame streams its bytes out in the order they were appended.
- R3: A data write is dropped whole when the selected channel has fewer than 4 free bytes. A channel that has taken 1024 words therefore sends only those 4096 bytes.
- R4: A length write above 4096 stores 4096. Smaller values are stored as written and read back unchanged.
- R5: A write with bit 0 set to a channel's start register begins a frame only while the enable bit (control bit 1) is 1. Otherwise nothing is sent and no status bit is set.
- R6: A frame sends the smaller of the stored length and the bytes held. Only the final byte of a frame carries tx_last.
- R7: A start with a stored length of 0, or with an empty channel, sends nothing and sets no status bit. The held data stays in the channel for a later frame.
- R8: After the final byte of a frame on channel n, that channel's buffer and length become 0 and status bit n (bit 0 for channel 0, bit 1 for channel 1) becomes 1.
- R9: irq equals the OR of (status AND enable), one cycle after the status or enable registers change. Writing 1s to the status register clears those bits.
- R10: A control write with bit 0 set clears the select register, interrupt enable, interrupt status, both lengths and both buffers, and aborts any frame. The control register then holds the written bit 1, with bit 0 read as 0.
- R11: While tx_valid is 1 and tx_ready is 0, tx_valid, tx_data and tx_last hold their values.
- R12: A start command issued while a frame is in progress is ignored. The other channel's data and length stay intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Interrupt request |
| tx_data | output | 8 | Outgoing frame byte |
| tx_valid | output | 1 | tx_data is valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Downstream accepts the byte |

## Verification
The hardest case to reach from the ports is the overflow corner. There, a channel is exactly full and one more word is written. The only visible effect is that the stream stops after byte 4096, without the extra word. The stimulus writes 1025 distinct words to one channel and programs a length of 5000, which is clamped. The scoreboard then expects exactly the first 4096 bytes, with tx_last on the last of them. A second hard case is a start that arrives mid-frame. The bench issues it while the other channel is stalled by a pseudo-random tx_ready pattern. It then checks that the status bit stays clear and that the untouched data still goes out later.

// File: rtl/dtf_pkg.sv
package dtf_pkg;
  localparam int NUM_CH = 2;
  localparam int CHW    = $clog2(NUM_CH);

  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_SEL   = 8'h04;
  localparam logic [7:0] A_LEN0  = 8'h08;
  localparam logic [7:0] A_GO0   = 8'h10;
  localparam logic [7:0] A_DATA  = 8'h18;
  localparam logic [7:0] A_IEN   = 8'h1C;
  localparam logic [7:0] A_ISTAT = 8'h20;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_LOAD, ST_SEND} stream_state_e;
endpackage

// File: rtl/dtf_chan_buf.sv
module dtf_chan_buf #(
  parameter int DEPTH_BYTES = 4096,
  localparam int WORDS = DEPTH_BYTES / 4,
  localparam int WAW   = $clog2(WORDS),
  localparam int LEN_W = $clog2(DEPTH_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [31:0]      wdata,
  input  logic [WAW-1:0]   rd_addr,
  output logic [31:0]      rd_data,
  output logic [LEN_W-1:0] fill
);
  logic [31:0] mem [WORDS];
  logic [WAW:0] wcnt_q;
  logic room;

  // A whole word fits only while fewer than WORDS words are stored.
  assign room = (wcnt_q < (WAW+1)'(WORDS));
  assign fill = {wcnt_q, 2'b00};

  always_ff @(posedge clk) begin
    if (push && room) mem[wcnt_q[WAW-1:0]] <= wdata;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr)        wcnt_q <= '0;
    else if (push && room) wcnt_q <= wcnt_q + 1'b1;
  end
endmodule

// File: rtl/dtf_streamer.sv
module dtf_streamer
  import dtf_pkg::*;
#(
  parameter int DEPTH_BYTES = 4096,
  localparam int WAW   = $clog2(DEPTH_BYTES / 4),
  localparam int LEN_W = $clog2(DEPTH_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic             start,
  input  logic [CHW-1:0]   start_ch,
  input  logic [LEN_W-1:0] start_bytes,
  output logic [WAW-1:0]   rd_addr,
  input  logic [31:0]      rd_data,
  output logic             busy,
  output logic [CHW-1:0]   busy_ch,
  output logic             done,
  output logic [7:0]       tx_data,
  output logic             tx_valid,
  output logic             tx_last,
  input  logic             tx_ready
);
  stream_state_e st_q;
  logic [LEN_W-1:0] rem_q;
  logic [WAW-1:0]   wptr_q;
  logic [1:0]       lane_q;
  logic [CHW-1:0]   ch_q;
  logic [31:0]      hold_q;
  logic [7:0]       tx_data_q;
  logic             tx_valid_q, tx_last_q, done_q;

  assign rd_addr  = wptr_q;
  assign busy     = (st_q != ST_IDLE) || done_q;
  assign busy_ch  = ch_q;
  assign done     = done_q;
  assign tx_data  = tx_data_q;
  assign tx_valid = tx_valid_q;
  assign tx_last  = tx_last_q;

  always_ff @(posedge clk) begin
    done_q <= 1'b0;
    if (rst || abort) begin
      st_q       <= ST_IDLE;
      rem_q      <= '0;
      wptr_q     <= '0;
      lane_q     <= '0;
      ch_q       <= '0;
      hold_q     <= '0;
      tx_data_q  <= '0;
      tx_valid_q <= 1'b0;
      tx_last_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          rem_q  <= start_bytes;
          ch_q   <= start_ch;
          wptr_q <= '0;
          st_q   <= ST_FETCH;
        end
        ST_FETCH: begin
          wptr_q <= wptr_q + 1'b1;
          st_q   <= ST_LOAD;
        end
        ST_LOAD: begin
          hold_q     <= rd_data;
          tx_data_q  <= rd_data[7:0];
          tx_last_q  <= (rem_q == LEN_W'(1));
          tx_valid_q <= 1'b1;
          lane_q     <= 2'd0;
          st_q       <= ST_SEND;
        end
        ST_SEND: if (tx_ready) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) begin
            tx_valid_q <= 1'b0;
            tx_last_q  <= 1'b0;
            done_q     <= 1'b1;
            st_q       <= ST_IDLE;
          end else if (lane_q == 2'd3) begin
            tx_valid_q <= 1'b0;
            st_q       <= ST_FETCH;
          end else begin
            lane_q    <= lane_q + 2'd1;
            tx_data_q <= hold_q[{lane_q + 2'd1, 3'b000} +: 8];
            tx_last_q <= (rem_q == LEN_W'(2));
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dtf_regs.sv
module dtf_regs
  import dtf_pkg::*;
#(
  parameter int DEPTH_BYTES = 4096,
  localparam int LEN_W = $clog2(DEPTH_BYTES) + 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [7:0]                    reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  input  logic [NUM_CH-1:0][LEN_W-1:0]  fill,
  input  logic                          busy,
  input  logic [CHW-1:0]                busy_ch,
  input  logic                          done,
  output logic [NUM_CH-1:0]             push,
  output logic [NUM_CH-1:0]             clr,
  output logic                          start,
  output logic [CHW-1:0]                start_ch,
  output logic [LEN_W-1:0]              start_bytes,
  output logic                          soft_rst,
  output logic                          tx_enable,
  output logic [CHW-1:0]                sel,
  output logic [NUM_CH-1:0]             irq_en,
  output logic [NUM_CH-1:0]             irq_stat,
  output logic [NUM_CH-1:0][LEN_W-1:0]  len,
  output logic                          irq
);
  logic [NUM_CH-1:0][LEN_W-1:0] len_q;
  logic [NUM_CH-1:0] en_q, stat_q, stat_set;
  logic [CHW-1:0]    sel_q;
  logic              txen_q, irq_q;
  logic [31:0]       rdata_q;
  logic              go_hit;
  logic [CHW-1:0]    go_ch;
  logic [LEN_W-1:0]  req_len, have_len, clamped;

  assign soft_rst = reg_wr && (reg_addr == A_CTRL) && reg_wdata[0];
  assign clamped  = (reg_wdata > 32'(DEPTH_BYTES)) ? LEN_W'(DEPTH_BYTES)
                                                  : reg_wdata[LEN_W-1:0];

  always_comb begin
    go_hit = 1'b0;
    go_ch  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_wr && reg_wdata[0] && (reg_addr == A_GO0 + 8'(4*c))) begin
        go_hit = 1'b1;
        go_ch  = CHW'(c);
      end
    end
  end

  assign req_len     = len_q[go_ch];
  assign have_len    = fill[go_ch];
  assign start_bytes = (req_len < have_len) ? req_len : have_len;
  assign start_ch    = go_ch;
  assign start       = go_hit && txen_q && !busy && (start_bytes != '0);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign push[c]     = reg_wr && (reg_addr == A_DATA) && (sel_q == CHW'(c)) &&
                           !(busy && (busy_ch == CHW'(c)));
      assign stat_set[c] = done && (busy_ch == CHW'(c));
      assign clr[c]      = soft_rst || stat_set[c];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      txen_q <= 1'b0;
      sel_q  <= '0;
      en_q   <= '0;
      stat_q <= '0;
      len_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= |(stat_q & en_q);
      if (soft_rst) begin
        txen_q <= reg_wdata[1];
        sel_q  <= '0;
        en_q   <= '0;
        stat_q <= '0;
        len_q  <= '0;
      end else begin
        if (reg_wr && reg_addr == A_CTRL) txen_q <= reg_wdata[1];
        if (reg_wr && reg_addr == A_SEL)
          sel_q <= (reg_wdata < 32'(NUM_CH)) ? reg_wdata[CHW-1:0] : '0;
        if (reg_wr && reg_addr == A_IEN) en_q <= reg_wdata[NUM_CH-1:0];
        for (int c = 0; c < NUM_CH; c++) begin
          if (reg_wr && reg_addr == A_LEN0 + 8'(4*c)) len_q[c] <= clamped;
          if (stat_set[c]) len_q[c] <= '0;
        end
        if (reg_wr && reg_addr == A_ISTAT)
          stat_q <= (stat_q & ~reg_wdata[NUM_CH-1:0]) | stat_set;
        else
          stat_q <= stat_q | stat_set;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (reg_rd) begin
      rdata_q <= '0;
      case (reg_addr)
        A_CTRL:  rdata_q <= {30'd0, txen_q, 1'b0};
        A_SEL:   rdata_q <= 32'(sel_q);
        A_IEN:   rdata_q <= 32'(en_q);
        A_ISTAT: rdata_q <= 32'(stat_q);
        default: begin
          for (int c = 0; c < NUM_CH; c++)
            if (reg_addr == A_LEN0 + 8'(4*c)) rdata_q <= 32'(len_q[c]);
        end
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign tx_enable = txen_q;
  assign sel       = sel_q;
  assign irq_en    = en_q;
  assign irq_stat  = stat_q;
  assign len       = len_q;
  assign irq       = irq_q;
endmodule

// File: rtl/dual_tx_frame_fifo.sv
module dual_tx_frame_fifo
  import dtf_pkg::*;
#(
  parameter int DEPTH_BYTES = 4096,
  localparam int WAW   = $clog2(DEPTH_BYTES / 4),
  localparam int LEN_W = $clog2(DEPTH_BYTES) + 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_last,
  input  logic        tx_ready
);
  logic [NUM_CH-1:0][LEN_W-1:0] fill, len;
  logic [NUM_CH-1:0] push, clr, irq_en, irq_stat;
  logic [31:0]       buf_rd [NUM_CH];
  logic [WAW-1:0]    rd_addr;
  logic              stream_busy, stream_done, start, soft_rst, tx_enable;
  logic [CHW-1:0]    busy_ch, start_ch, sel;
  logic [LEN_W-1:0]  start_bytes;

  dtf_regs #(.DEPTH_BYTES(DEPTH_BYTES)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fill(fill), .busy(stream_busy),
    .busy_ch(busy_ch), .done(stream_done), .push(push), .clr(clr), .start(start),
    .start_ch(start_ch), .start_bytes(start_bytes), .soft_rst(soft_rst),
    .tx_enable(tx_enable), .sel(sel), .irq_en(irq_en), .irq_stat(irq_stat),
    .len(len), .irq(irq)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_buf
      dtf_chan_buf #(.DEPTH_BYTES(DEPTH_BYTES)) u_buf (
        .clk(clk), .rst(rst), .clr(clr[c]), .push(push[c]), .wdata(reg_wdata),
        .rd_addr(rd_addr), .rd_data(buf_rd[c]), .fill(fill[c])
      );
    end
  endgenerate

  dtf_streamer #(.DEPTH_BYTES(DEPTH_BYTES)) u_stream (
    .clk(clk), .rst(rst), .abort(soft_rst), .start(start), .start_ch(start_ch),
    .start_bytes(start_bytes), .rd_addr(rd_addr), .rd_data(buf_rd[busy_ch]),
    .busy(stream_busy), .busy_ch(busy_ch), .done(stream_done), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready)
  );
endmodule

// File: rtl/dtf_checker.sv
module dtf_checker
  import dtf_pkg::*;
#(
  parameter int DEPTH_BYTES = 4096,
  localparam int LEN_W = $clog2(DEPTH_BYTES) + 1
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         tx_valid,
  input logic                         tx_ready,
  input logic [7:0]                   tx_data,
  input logic                         tx_last,
  input logic                         irq,
  input logic [NUM_CH-1:0]            stat,
  input logic [NUM_CH-1:0]            en,
  input logic                         tx_en,
  input logic                         busy,
  input logic                         done,
  input logic [CHW-1:0]               done_ch,
  input logic                         soft_rst,
  input logic [CHW-1:0]               sel,
  input logic [NUM_CH-1:0][LEN_W-1:0] len
);
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  p_irq_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(stat & en))));

  p_gate_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(tx_en));

  p_last_r6: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);

  p_status_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !soft_rst) |=> stat[$past(done_ch)]);

  p_sreset_r10: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (stat == '0 && en == '0 && sel == '0 && !busy && !tx_valid));

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_len
      p_clamp_r4: assert property (@(posedge clk) disable iff (rst)
        len[c] <= LEN_W'(DEPTH_BYTES));
    end
  endgenerate
endmodule

bind dual_tx_frame_fifo dtf_checker #(.DEPTH_BYTES(DEPTH_BYTES)) u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_last(tx_last), .irq(irq), .stat(irq_stat), .en(irq_en), .tx_en(tx_enable),
  .busy(stream_busy), .done(stream_done), .done_ch(busy_ch), .soft_rst(soft_rst),
  .sel(sel), .len(len)
);

// File: tb/dual_tx_frame_fifo_test.sv
module dual_tx_frame_fifo_test;
  localparam int DEPTH = 4096;
  localparam logic [7:0] A_CTRL = 8'h00, A_SEL = 8'h04, A_LEN0 = 8'h08, A_LEN1 = 8'h0C,
                         A_GO0 = 8'h10, A_GO1 = 8'h14, A_DATA = 8'h18, A_IEN = 8'h1C,
                         A_ISTAT = 8'h20;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, tx_valid, tx_last, tx_ready;
  logic [7:0] tx_data;

  dual_tx_frame_fifo uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  bit         exp_last_q[$];
  logic [7:0] m_buf0[$], m_buf1[$];
  int  m_len[2];
  bit  m_en = 1'b0;
  int  m_sel = 0;
  bit  stall_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Downstream ready pattern
  initial begin
    tx_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_ready = stall_on ? (lfsr[0] | lfsr[3]) : 1'b1;
    end
  end

  // Monitor / scoreboard
  bit prev_stall = 1'b0;
  logic [7:0] prev_data;
  bit prev_last;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall)
        chk(tx_valid && tx_data == prev_data && tx_last == prev_last,
            "R11 output held under back-pressure", {tx_valid, tx_data}, {1'b1, prev_data});
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      prev_last  = tx_last;
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected byte on stream", tx_data, 0);
        else begin
          logic [7:0] e;
          bit el;
          e  = exp_q.pop_front();
          el = exp_last_q.pop_front();
          chk(tx_data == e, "R2 byte order", tx_data, e);
          chk(tx_last == el, "R6 last flag", tx_last, el);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic set_sel(input int v);
    wr(A_SEL, 32'(v));
    m_sel = (v >= 0 && v < 2) ? v : 0;
  endtask

  task automatic set_len(input int ch, input int v);
    wr(ch == 0 ? A_LEN0 : A_LEN1, 32'(v));
    m_len[ch] = (v > DEPTH) ? DEPTH : v;
  endtask

  task automatic push_word(input logic [31:0] d);
    wr(A_DATA, d);
    for (int i = 0; i < 4; i++) begin
      if (m_sel == 0) begin if (m_buf0.size() + 4 - i <= DEPTH) m_buf0.push_back(d[8*i +: 8]); end
      else begin if (m_buf1.size() + 4 - i <= DEPTH) m_buf1.push_back(d[8*i +: 8]); end
    end
  endtask

  task automatic go(input int ch);
    int have, n;
    wr(ch == 0 ? A_GO0 : A_GO1, 32'h1);
    have = (ch == 0) ? m_buf0.size() : m_buf1.size();
    n = (m_len[ch] < have) ? m_len[ch] : have;
    if (m_en && n > 0) begin
      for (int i = 0; i < n; i++) begin
        exp_q.push_back(ch == 0 ? m_buf0[i] : m_buf1[i]);
        exp_last_q.push_back(i == n - 1);
      end
      if (ch == 0) m_buf0.delete(); else m_buf1.delete();
      m_len[ch] = 0;
    end
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 100000) begin @(posedge clk); n++; end
    repeat (6) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    m_len[0] = 0; m_len[1] = 0;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(tx_valid == 1'b0, "R10 reset tx_valid", tx_valid, 0);
    chk(irq == 1'b0, "R9 reset irq", irq, 0);
    rd(A_CTRL, v);  chk(v == 0, "R10 reset control", v, 0);

    // R1 channel select
    set_sel(1); rd(A_SEL, v); chk(v == 1, "R1 select 1", v, 1);
    set_sel(5); rd(A_SEL, v); chk(v == 0, "R1 select out of range", v, 0);

    wr(A_CTRL, 32'h2); m_en = 1'b1;
    wr(A_IEN, 32'h3);

    // R2 basic frame on channel 0
    set_sel(0);
    push_word(32'h44332211); push_word(32'h88776655); push_word(32'hCCBBAA99);
    set_len(0, 12); go(0); drain();
    rd(A_ISTAT, v); chk(v == 1, "R8 status bit 0", v, 1);
    rd(A_LEN0, v);  chk(v == 0, "R8 length cleared", v, 0);
    @(negedge clk); chk(irq == 1'b1, "R9 irq asserted", irq, 1);
    wr(A_ISTAT, 32'h1);
    rd(A_ISTAT, v); chk(v == 0, "R9 write-1 clear", v, 0);
    @(negedge clk); chk(irq == 1'b0, "R9 irq dropped", irq, 0);

    // R6 length beyond held bytes, with back-pressure
    stall_on = 1'b1;
    set_sel(1);
    push_word(32'hDEADBEEF); push_word(32'h01234567);
    set_len(1, 20); go(1); drain();
    rd(A_ISTAT, v); chk(v == 2, "R8 status bit 1", v, 2);
    wr(A_ISTAT, 32'h2);

    // R7 zero length keeps data
    set_sel(0);
    push_word(32'hA5A55A5A);
    set_len(0, 0); go(0); repeat (20) @(posedge clk);
    rd(A_ISTAT, v); chk(v == 0, "R7 no status on zero length", v, 0);
    set_len(0, 4); go(0); drain();
    wr(A_ISTAT, 32'h3);
    // R8 channel emptied: a new start finds nothing
    set_len(0, 8); go(0); repeat (20) @(posedge clk);
    rd(A_ISTAT, v); chk(v == 0, "R8 buffer emptied after frame", v, 0);

    // R5 start gated by enable
    wr(A_CTRL, 32'h0); m_en = 1'b0;
    push_word(32'h0BADF00D);
    set_len(0, 4); go(0); repeat (20) @(posedge clk);
    rd(A_ISTAT, v); chk(v == 0, "R5 no start while disabled", v, 0);
    wr(A_CTRL, 32'h2); m_en = 1'b1;
    go(0); drain();
    wr(A_ISTAT, 32'h3);

    // R12 start while busy ignored
    set_sel(0);
    for (int i = 0; i < 4; i++) push_word(32'h10203040 + 32'(i));
    set_sel(1); push_word(32'hFACECAFE);
    set_len(0, 16); set_len(1, 4);
    go(0);
    wr(A_GO1, 32'h1);
    drain();
    rd(A_ISTAT, v); chk(v == 1, "R12 busy start ignored", v, 1);
    go(1); drain();
    rd(A_ISTAT, v); chk(v == 3, "R12 other channel sent later", v, 3);
    wr(A_ISTAT, 32'h3);
    stall_on = 1'b0;

    // R4 clamp and R3 overflow drop
    set_len(1, 5000); rd(A_LEN1, v); chk(v == DEPTH, "R4 length clamp", v, DEPTH);
    set_len(1, 77);   rd(A_LEN1, v); chk(v == 77, "R4 length stored", v, 77);
    set_len(1, 5000);
    set_sel(1);
    for (int i = 0; i < 1025; i++) push_word(32'(i) * 32'h9E3779B1 + 32'h13579BDF);
    chk(m_buf1.size() == DEPTH, "R3 model fill", m_buf1.size(), DEPTH);
    go(1); drain();
    rd(A_ISTAT, v); chk(v == 2, "R3 full frame completed", v, 2);

    // R10 soft reset
    set_len(0, 20); push_word(32'h77777777);
    wr(A_CTRL, 32'h1);
    m_en = 1'b0; m_sel = 0; m_len[0] = 0; m_len[1] = 0;
    m_buf0.delete(); m_buf1.delete();
    rd(A_CTRL, v);  chk(v == 0, "R10 control", v, 0);
    rd(A_SEL, v);   chk(v == 0, "R10 select", v, 0);
    rd(A_IEN, v);   chk(v == 0, "R10 enable", v, 0);
    rd(A_ISTAT, v); chk(v == 0, "R10 status", v, 0);
    rd(A_LEN0, v);  chk(v == 0, "R10 length", v, 0);
    @(negedge clk); chk(irq == 0, "R10 irq", irq, 0);
    wr(A_CTRL, 32'h2); m_en = 1'b1;
    set_len(1, 4); go(1); repeat (20) @(posedge clk);
    rd(A_ISTAT, v); chk(v == 0, "R10 buffers emptied", v, 0);

    drain();
    chk(exp_q.size() == 0, "R2 all expected bytes seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule